// File: doc/BRIEF.md
# Millisecond Interval Timer

This block is a 16-bit down-counting interval timer. While running, it subtracts one from its count register once per millisecond. An internal prescaler derives that period from the system clock frequency. Software-visible operations arrive as single-cycle strobes. A load strobe writes a new count. Start and stop strobes turn counting on and off. A test strobe samples the running state. The current count is always visible on an output port, so a store operation reads it from there.

Start and stop report in the B flag whether the timer was already running before the command. The test command reports the running state in the Z flag. When a decrement takes the count from one to zero, the timer raises a one-cycle interrupt request. It keeps counting past zero, wrapping to all ones, until it is told to stop. The block has no halt input, so a halted processor does not pause it. The surrounding logic handles interrupt arbitration and the memory side of load and store.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset the count is 0, the timer is stopped, both flags are 0 and the interrupt request is low.
- R2: A load strobe makes count_o equal load_data_i one cycle later, whether the timer is running or stopped. If a load and a decrement fall on the same cycle, the load wins and the decrement is lost.
- R3: While running, the count drops by exactly one every CLK_HZ/TICK_HZ clock cycles. The first drop comes that many cycles after a start issued while stopped. While stopped, the count never changes except by load.
- R4: A start strobe sets the running state and a stop strobe clears it; if both arrive together, stop wins. One cycle after either strobe, flag_b_o equals the running state before the strobe.
- R5: One cycle after a test strobe, flag_z_o equals the running state before the strobe. A test strobe leaves flag_b_o and the running state unchanged.
- R6: When a decrement takes the count from 1 to 0, irq_o is high for exactly one cycle, the cycle in which count_o first shows 0.
- R7: A decrement from 0 yields 16'hFFFF and counting continues. Neither the wrap nor a load of 0 raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for the count register |
| load_data_i | input | CNT_W | Value written by a load |
| start_i | input | 1 | Start command strobe |
| stop_i | input | 1 | Stop command strobe |
| test_i | input | 1 | Test command strobe |
| count_o | output | CNT_W | Current count (store path) |
| running_o | output | 1 | Timer is counting |
| flag_b_o | output | 1 | Running state before the last start or stop |
| flag_z_o | output | 1 | Running state at the last test |
| irq_o | output | 1 | One-cycle interrupt request on reaching zero |

## Verification
A wrong prescaler phase or period shows up one tick late or early at count_o. That is within one millisecond period of a start, because the bench samples at exact multiples of the period. A wrong running bit shows up in the next flag result, or as a count that moves or stalls at the next tick. A bad zero detector either misses the irq_o pulse in the cycle count_o first reads 0, or fires a pulse at the wrap or after a load of zero. The bench watches irq_o on every cycle through those windows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic b;
    logic z;
  } tmr_flags_t;

  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_B    = 2'd1,
    FLG_Z    = 2'd2
  } flag_op_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  generate
    if (DIV <= 1) begin : g_pass
      assign cnt_q  = '0;
      assign tick_o = 1'b1;
    end else begin : g_div
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (restart_i || cnt_q == LAST) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST) && !restart_i;
    end
  endgenerate
endmodule

// File: rtl/tmr_run_ctrl.sv
module tmr_run_ctrl
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       test_i,
  output logic       running_o,
  output tmr_flags_t flags_o
);
  logic       run_q;
  tmr_flags_t flg_q;
  flag_op_e   op;

  always_comb begin
    op = FLG_HOLD;
    if (start_i || stop_i) op = FLG_B;
    else if (test_i)       op = FLG_Z;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      flg_q <= '0;
    end else begin
      // stop has priority over start
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
      unique case (op)
        FLG_B:   flg_q.b <= run_q;
        FLG_Z:   flg_q.z <= run_q;
        default: ;
      endcase
      if (op == FLG_B && test_i) flg_q.z <= run_q;
    end
  end

  assign running_o = run_q;
  assign flags_o   = flg_q;
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             hit_zero;

  assign hit_zero = dec_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (load_i)     cnt_q <= load_data_i;
      else if (dec_i) cnt_q <= cnt_q - ONE;  // wraps from zero
      irq_q <= hit_zero;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CLK_HZ  = 125000000,
  parameter int unsigned TICK_HZ = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             test_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             flag_b_o,
  output logic             flag_z_o,
  output logic             irq_o
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic       tick;
  logic       restart;
  tmr_flags_t flags;

  // phase of the period starts at a start issued while stopped
  assign restart = start_i && !stop_i && !running_o;

  tmr_prescaler #(.DIV(DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_o    (tick)
  );

  tmr_run_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .test_i    (test_i),
    .running_o (running_o),
    .flags_o   (flags)
  );

  tmr_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .dec_i       (running_o && tick),
    .count_o     (count_o),
    .irq_o       (irq_o)
  );

  assign flag_b_o = flags.b;
  assign flag_z_o = flags.z;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [CNT_W-1:0] load_data_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             test_i,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic             flag_b_o,
  input logic             flag_z_o,
  input logic             irq_o
);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_data_i));

  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !load_i) |=> $stable(count_o));

  assert_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o);

  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> running_o);

  assert_flag_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> flag_b_o == $past(running_o));

  assert_flag_z_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> flag_z_o == $past(running_o));

  assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count_o == '0);

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(count_o) == CNT_W'(1));
endmodule

bind ms_interval_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .test_i      (test_i),
  .count_o     (count_o),
  .running_o   (running_o),
  .flag_b_o    (flag_b_o),
  .flag_z_o    (flag_z_o),
  .irq_o       (irq_o)
);

// File: tb/tb_ms_interval_timer.sv
module tb_ms_interval_timer;
  localparam int P = 8;  // cycles per tick with the bench parameters

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        test_i = 1'b0;
  logic [15:0] count_o;
  logic        running_o, flag_b_o, flag_z_o, irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ms_interval_timer #(.CNT_W(16), .CLK_HZ(8000), .TICK_HZ(1000)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_data_i(load_data_i),
    .start_i(start_i), .stop_i(stop_i), .test_i(test_i), .count_o(count_o),
    .running_o(running_o), .flag_b_o(flag_b_o), .flag_z_o(flag_z_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_load(input logic [15:0] v);
    load_i = 1'b1; load_data_i = v; cyc(1); load_i = 1'b0;
  endtask
  task automatic do_start(); start_i = 1'b1; cyc(1); start_i = 1'b0; endtask
  task automatic do_stop();  stop_i  = 1'b1; cyc(1); stop_i  = 1'b0; endtask
  task automatic do_test();  test_i  = 1'b1; cyc(1); test_i  = 1'b0; endtask

  task automatic t_reset();
    chk("R1 count", count_o, 0);
    chk("R1 running", running_o, 0);
    chk("R1 flag_b", flag_b_o, 0);
    chk("R1 flag_z", flag_z_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_load_idle();
    do_load(16'h1234);
    chk("R2 load while stopped", count_o, 16'h1234);
    cyc(3 * P);
    chk("R3 stopped holds", count_o, 16'h1234);
  endtask

  task automatic t_count_flags();
    logic [15:0] held;
    do_start();
    chk("R4 running after start", running_o, 1);
    chk("R4 B after start from stopped", flag_b_o, 0);
    cyc(P - 1);
    chk("R3 no early tick", count_o, 16'h1234);
    cyc(1);
    chk("R3 first tick", count_o, 16'h1233);
    cyc(2 * P);
    chk("R3 third tick", count_o, 16'h1231);
    do_test();
    chk("R5 Z when running", flag_z_o, 1);
    chk("R5 test keeps B", flag_b_o, 0);
    do_start();
    chk("R4 B on start while running", flag_b_o, 1);
    do_stop();
    chk("R4 stopped", running_o, 0);
    chk("R4 B on stop while running", flag_b_o, 1);
    held = count_o;
    cyc(3 * P);
    chk("R3 no count after stop", count_o, held);
    do_stop();
    chk("R4 B on stop while stopped", flag_b_o, 0);
    do_test();
    chk("R5 Z when stopped", flag_z_o, 0);
    chk("R5 test keeps running", running_o, 0);
  endtask

  task automatic t_irq_wrap();
    int pulses;
    do_load(16'd2);
    do_start();
    cyc(P);
    chk("R3 2->1", count_o, 1);
    chk("R6 no irq at 1", irq_o, 0);
    cyc(P);
    chk("R6 count zero", count_o, 0);
    chk("R6 irq with zero", irq_o, 1);
    cyc(1);
    chk("R6 irq single cycle", irq_o, 0);
    pulses = 0;
    for (int i = 0; i < P - 1; i++) begin
      if (irq_o) pulses++;
      cyc(1);
    end
    chk("R7 wrap value", count_o, 16'hFFFF);
    for (int i = 0; i < 2 * P; i++) begin
      if (irq_o) pulses++;
      cyc(1);
    end
    chk("R7 keeps counting", count_o, 16'hFFFD);
    chk("R7 no irq on wrap", pulses, 0);
    do_load(16'd0);
    pulses = 0;
    for (int i = 0; i < P + 2; i++) begin
      if (irq_o) pulses++;
      cyc(1);
    end
    chk("R7 no irq on load zero", pulses, 0);
    chk("R7 running load zero wraps", count_o, 16'hFFFF);
    do_stop();
  endtask

  task automatic t_load_vs_tick();
    do_load(16'd50);
    do_start();
    cyc(P - 1);
    do_load(16'd100);  // edge coincides with a tick
    chk("R2 load beats tick", count_o, 16'd100);
    cyc(P - 1);
    chk("R2 no double step", count_o, 16'd100);
    cyc(1);
    chk("R3 next tick after load", count_o, 16'd99);
    do_stop();
  endtask

  task automatic t_start_stop_same();
    start_i = 1'b1; stop_i = 1'b1; cyc(1); start_i = 1'b0; stop_i = 1'b0;
    chk("R4 stop wins", running_o, 0);
    chk("R4 B with both", flag_b_o, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_load_idle();
    t_count_flags();
    t_irq_wrap();
    t_load_vs_tick();
    t_start_stop_same();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule